// File: doc/BRIEF.md
# Virtual-Channel Receive Demultiplexer

This block sits behind one physical link and receives that link's frames in order. It splits the single stream into eight independent tagged streams. Each beat of a frame carries a channel tag. The beat is written into the reception FIFO owned by that channel, so traffic from different software threads never shares a buffer. A frame is a run of beats that ends with a beat whose `in_last` is set. The usual payload is 128 bytes, which is 32 beats of 32 bits. The block does not check the length of a frame.

A channel accepts data only after the host has granted it credit. A grant carries a number of frames. The channel's counter drops by one each time the last beat of a frame is stored. When the counter reaches zero, the channel's completion flag goes high and software can poll it. The usual host sequence is: grant credit, let the sender transmit, then poll the flag.

The input is a valid/ready stream. `in_valid` with `in_ready` low means the beat waits. Whether `in_ready` is high depends only on the channel named by the beat that is on the bus. When that channel has no credit or a full FIFO, the beat is held back. A beat for any other channel that has credit and space is still accepted. Each output read port is also valid/ready. Its data stays steady while `out_valid` is high and `out_ready` is low.

Top module: `vc_rx_demux`

## Requirements
- R1: After reset every channel counter is zero, every completion flag is low, every `out_valid` is low, and `in_ready` is low for any tag.
- R2: A beat accepted with tag `in_vc` (3 bits, value k selects channel k) is written into FIFO k together with its `in_last` bit. Beats come out of that FIFO in the order they were accepted.
- R3: `in_ready` is high exactly when the channel named by `in_vc` has a nonzero credit counter and a FIFO that is not full. A stall on one channel does not block a beat for another channel that is ready.
- R4: A grant of N > 0 frames on channel k adds N to counter k. Accepting a beat with `in_last` set on channel k subtracts one. A channel whose counter is zero accepts nothing.
- R5: `vc_done[k]` rises on the first clock edge after the accepted last beat that brings counter k to zero. It falls on the first clock edge after a nonzero grant on channel k.
- R6: A grant of zero frames has no effect: the counter and the completion flag keep their values.
- R7: Each FIFO holds FIFO_DEPTH beats (64 by default). When a FIFO is full, `in_ready` is low for beats with its tag.
- R8: `out_valid[k]` is high while FIFO k holds data. The head beat on `out_data`/`out_last` stays steady until it is popped with `out_ready[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_vc | input | 3 | Channel tag of the beat |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Final beat of a frame |
| cred_we | input | 8 | Per-channel credit grant strobe |
| cred_num | input | 64 | Per-channel frame count, 8 bits per channel |
| out_valid | output | 8 | Per-channel head beat present |
| out_ready | input | 8 | Per-channel pop |
| out_data | output | 256 | Per-channel head payload, 32 bits per channel |
| out_last | output | 8 | Per-channel head end-of-frame marker |
| vc_done | output | 8 | Per-channel completion flag |

## Verification
The assertions assume the following about the inputs:
- The tag stays the same on every beat of a frame.
- A grant never pushes a counter past its 8-bit range.
- The sender never ends more frames than the credit it was granted.

The bench keeps to these rules. Every frame it sends is built with one fixed tag. Its grants are at most three frames. Its sending task waits for `in_ready` before each beat, so it never sends beyond the credit. A probe beat for a channel without credit is withdrawn before any beat is accepted.

// File: rtl/vc_rx_pkg.sv
package vc_rx_pkg;
  typedef enum logic {
    PH_HEAD = 1'b0,
    PH_BODY = 1'b1
  } rx_phase_e;
endpackage

// File: rtl/vc_fifo.sv
module vc_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   level;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      level <= level + (AW+1)'(wr_en) - (AW+1)'(rd_en);
    end
  end

  assign rd_data  = mem[rd_ptr];
  assign rd_valid = (level != '0);
  assign full     = (level == (AW+1)'(DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_valid);
endmodule

// File: rtl/vc_credit.sv
module vc_credit #(
  parameter int CRED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_we,
  input  logic [CRED_W-1:0] grant_num,
  input  logic              frame_done,
  output logic              has_credit,
  output logic              done
);
  logic [CRED_W-1:0] cnt;
  logic [CRED_W:0]   sum;
  logic              grant_live;

  assign grant_live = grant_we && (grant_num != '0);
  assign sum        = {1'b0, cnt} + {1'b0, grant_num};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (grant_live) begin
      cnt  <= sum[CRED_W-1:0] - CRED_W'(frame_done);
      done <= 1'b0;
    end else if (frame_done) begin
      cnt <= cnt - 1'b1;
      if (cnt == CRED_W'(1)) done <= 1'b1;
    end
  end

  assign has_credit = (cnt != '0);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> has_credit);
  assert_grant_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_live |-> !sum[CRED_W]);
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_live |=> !done);
  assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done ##1 done |-> $past(frame_done));
  assert_zero_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_we && grant_num == '0 && !frame_done) |=> ($stable(cnt) && $stable(done)));
endmodule

// File: rtl/vc_rx_demux.sv
module vc_rx_demux #(
  parameter int NUM_VC     = 8,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 64,
  parameter int CRED_W     = 8,
  localparam int VC_W      = $clog2(NUM_VC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [VC_W-1:0]          in_vc,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     in_last,
  input  logic [NUM_VC-1:0]        cred_we,
  input  logic [NUM_VC*CRED_W-1:0] cred_num,
  output logic [NUM_VC-1:0]        out_valid,
  input  logic [NUM_VC-1:0]        out_ready,
  output logic [NUM_VC*DATA_W-1:0] out_data,
  output logic [NUM_VC-1:0]        out_last,
  output logic [NUM_VC-1:0]        vc_done
);
  import vc_rx_pkg::*;

  localparam int EW = DATA_W + 1;

  logic [NUM_VC-1:0] fifo_full, credit_ok, wr_en, rd_en, frame_end;
  logic              accept;
  rx_phase_e         phase;
  logic [VC_W-1:0]   held_vc;

  assign in_ready = credit_ok[in_vc] & ~fifo_full[in_vc];
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_HEAD;
      held_vc <= '0;
    end else if (accept) begin
      phase   <= in_last ? PH_HEAD : PH_BODY;
      held_vc <= in_vc;
    end
  end

  for (genvar k = 0; k < NUM_VC; k++) begin : g_vc
    logic [EW-1:0] head;

    assign wr_en[k]     = accept && (in_vc == VC_W'(k));
    assign frame_end[k] = wr_en[k] && in_last;
    assign rd_en[k]     = out_valid[k] && out_ready[k];

    vc_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en[k]),
      .wr_data  ({in_last, in_data}),
      .rd_en    (rd_en[k]),
      .rd_data  (head),
      .rd_valid (out_valid[k]),
      .full     (fifo_full[k])
    );

    vc_credit #(.CRED_W(CRED_W)) u_credit (
      .clk        (clk),
      .rst_n      (rst_n),
      .grant_we   (cred_we[k]),
      .grant_num  (cred_num[k*CRED_W +: CRED_W]),
      .frame_done (frame_end[k]),
      .has_credit (credit_ok[k]),
      .done       (vc_done[k])
    );

    assign out_data[k*DATA_W +: DATA_W] = head[DATA_W-1:0];
    assign out_last[k]                  = head[DATA_W];

    assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[k] && !out_ready[k]) |=>
        (out_valid[k] && $stable(out_data[k*DATA_W +: DATA_W]) && $stable(out_last[k])));
  end

  assert_tag_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BODY && in_valid) |-> (in_vc == held_vc));
  assert_stall_no_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !credit_ok[in_vc]) |-> !in_ready);
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (out_valid == '0 && vc_done == '0 && !in_ready));
endmodule

// File: tb/tb_vc_rx_demux.sv
module tb_vc_rx_demux;
  localparam int NUM_VC = 8;
  localparam int DATA_W = 32;
  localparam int CRED_W = 8;
  localparam int BEATS  = 32;
  localparam int DEPTH  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_vc = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic [NUM_VC-1:0] cred_we = '0;
  logic [NUM_VC*CRED_W-1:0] cred_num = '0;
  logic [NUM_VC-1:0] out_valid;
  logic [NUM_VC-1:0] out_ready = '1;
  logic [NUM_VC*DATA_W-1:0] out_data;
  logic [NUM_VC-1:0] out_last;
  logic [NUM_VC-1:0] vc_done;

  int checks = 0;
  int errors = 0;
  int acc_cnt [NUM_VC];
  logic toggle_hi = 1'b0;
  logic [DATA_W:0] sbq [NUM_VC][$];

  always #4 clk = ~clk;

  vc_rx_demux dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vc(in_vc), .in_data(in_data), .in_last(in_last),
    .cred_we(cred_we), .cred_num(cred_num), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .vc_done(vc_done)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: called at a negedge; returns at the negedge after acceptance.
  task automatic send_beat(input int ch, input logic [DATA_W-1:0] d, input logic last);
    in_valid = 1'b1;
    in_vc    = 3'(ch);
    in_data  = d;
    in_last  = last;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    sbq[ch].push_back({last, d});
    acc_cnt[ch]++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input int ch, input int fid);
    for (int b = 0; b < BEATS; b++)
      send_beat(ch, {8'(ch), 8'(fid), 16'(b)} ^ 32'h5a00_0000, b == BEATS-1);
  endtask

  task automatic grant(input int ch, input int n);
    cred_we[ch] = 1'b1;
    cred_num[ch*CRED_W +: CRED_W] = CRED_W'(n);
    @(negedge clk);
    cred_we[ch] = 1'b0;
    cred_num[ch*CRED_W +: CRED_W] = '0;
  endtask

  // Monitor: pops happen at the posedge following this sample point.
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      for (int ch = 0; ch < NUM_VC; ch++) begin
        if (out_valid[ch] && out_ready[ch]) begin
          if (sbq[ch].size() == 0) begin
            check(1'b0, "R2 unexpected beat", 64'(out_data[ch*DATA_W +: DATA_W]), 64'h0);
          end else begin
            logic [DATA_W:0] e;
            e = sbq[ch].pop_front();
            check({out_last[ch], out_data[ch*DATA_W +: DATA_W]} == e, "R2 routed beat",
                  64'({out_last[ch], out_data[ch*DATA_W +: DATA_W]}), 64'(e));
          end
        end
      end
    end
  end

  // Ready toggler for channels 4..7
  always @(negedge clk) begin
    if (toggle_hi) out_ready[7:4] <= ~out_ready[7:4];
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] held;
    for (int i = 0; i < NUM_VC; i++) acc_cnt[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    check(out_valid == '0, "R1 out_valid", 64'(out_valid), 64'h0);
    check(vc_done == '0, "R1 vc_done", 64'(vc_done), 64'h0);
    check(in_ready == 1'b0, "R1 in_ready", 64'(in_ready), 64'h0);
    @(negedge clk);

    // R3/R4: no credit -> stall
    in_valid = 1'b1; in_vc = 3'd0; in_data = 32'h1; in_last = 1'b1;
    #2;
    check(in_ready == 1'b0, "R4 zero credit stall", 64'(in_ready), 64'h0);
    @(negedge clk);
    in_valid = 1'b0;

    // R4/R5: two frames of credit on channel 1
    grant(1, 2);
    send_frame(1, 0);
    #2;
    check(vc_done[1] == 1'b0, "R4 one frame left", 64'(vc_done[1]), 64'h0);
    @(negedge clk);
    send_frame(1, 1);
    #2;
    check(vc_done[1] == 1'b1, "R5 done set", 64'(vc_done[1]), 64'h1);
    @(negedge clk);

    // R3: channel 1 exhausted stalls, channel 2 with credit proceeds
    grant(2, 1);
    in_valid = 1'b1; in_vc = 3'd1; in_data = 32'h77; in_last = 1'b0;
    #2;
    check(in_ready == 1'b0, "R3 exhausted channel stalls", 64'(in_ready), 64'h0);
    in_vc = 3'd2;
    #1;
    check(in_ready == 1'b1, "R3 other channel ready", 64'(in_ready), 64'h1);
    in_valid = 1'b0;
    @(negedge clk);
    send_frame(2, 0);
    #2;
    check(vc_done[2] == 1'b1, "R5 done ch2", 64'(vc_done[2]), 64'h1);
    @(negedge clk);

    // R6: zero grant ignored
    grant(1, 0);
    #2;
    check(vc_done[1] == 1'b1, "R6 zero grant keeps done", 64'(vc_done[1]), 64'h1);
    in_valid = 1'b1; in_vc = 3'd1; in_last = 1'b0;
    #1;
    check(in_ready == 1'b0, "R6 zero grant gives no credit", 64'(in_ready), 64'h0);
    in_valid = 1'b0;
    @(negedge clk);
    // R5: nonzero grant clears done
    grant(1, 1);
    #2;
    check(vc_done[1] == 1'b0, "R5 grant clears done", 64'(vc_done[1]), 64'h0);
    @(negedge clk);
    send_frame(1, 2);
    #2;
    check(vc_done[1] == 1'b1, "R5 done after refill", 64'(vc_done[1]), 64'h1);
    @(negedge clk);

    // R7/R8: fill FIFO of channel 3 with its reader stalled
    out_ready[3] = 1'b0;
    grant(3, 3);
    fork
      begin
        send_frame(3, 0);
        send_frame(3, 1);
        send_frame(3, 2);
      end
      begin
        wait (acc_cnt[3] == DEPTH);
        @(negedge clk);
        held = out_data[3*DATA_W +: DATA_W];
        repeat (3) @(negedge clk);
        #2;
        check(in_ready == 1'b0 && in_valid, "R7 full FIFO stalls", 64'(in_ready), 64'h0);
        check(acc_cnt[3] == DEPTH, "R7 depth", 64'(acc_cnt[3]), 64'(DEPTH));
        check(out_data[3*DATA_W +: DATA_W] == held && out_valid[3], "R8 head held",
              64'(out_data[3*DATA_W +: DATA_W]), 64'(held));
        @(negedge clk);
        out_ready[3] = 1'b1;
      end
    join
    #2;
    check(vc_done[3] == 1'b1, "R5 done ch3", 64'(vc_done[3]), 64'h1);
    @(negedge clk);

    // R2: frames on several channels with toggling readers
    for (int ch = 4; ch < 8; ch++) grant(ch, 1);
    grant(0, 1);
    toggle_hi = 1'b1;
    for (int ch = 4; ch < 8; ch++) send_frame(ch, ch);
    send_frame(0, 9);
    toggle_hi = 1'b0;
    @(negedge clk);
    out_ready = '1;
    repeat (80) @(negedge clk);
    #2;
    check(vc_done[7:4] == 4'hf && vc_done[0], "R5 done multi", 64'(vc_done), 64'hff);
    for (int ch = 0; ch < NUM_VC; ch++)
      check(sbq[ch].size() == 0, "R2 all beats delivered", 64'(sbq[ch].size()), 64'h0);
    check(out_valid == '0, "R8 FIFOs drained", 64'(out_valid), 64'h0);
    finish_run();
  end
endmodule